// File: doc/BRIEF.md
# Systolic Stack Sorter

This block sorts a burst of unsigned keys with a linear chain of compare-exchange cells. Each cell holds two key slots and a single comparator. It talks only to the cell directly above it and the cell directly below it. The cell at the top of the chain faces the ports. A chain of `PE_CNT` cells holds up to `2*PE_CNT` keys.

Keys are written through an input stream and read back in ascending order through an output stream. Both streams use valid/ready handshakes, and a transfer happens in any cycle where valid and ready are both high.

- While keys are being written, each cell keeps the smaller of its resident key and the arriving key. It hands the larger one down to the cell below.
- When a key is read, the flow turns around. Each cell hands its smaller key up to the cell above, and the smaller key of the top cell is the output.
- The chain moves only on an accepted transfer, so stalls on either side are free.
- Reading may start in the cycle right after the last write. Reads then continue one per cycle.
- Once a read has been accepted, the input stays closed until the sorter is empty again.
- `in_ready` depends combinationally on `out_ready`. A source must not make `in_valid` depend on `in_ready`.
- A consumer may hold `out_ready` low for as long as it likes. The offered key stays put as long as no write is accepted.

Top module: `sstack_sorter`

## Requirements
- R1: A synchronous active-high reset, applied at any time, leaves `occupancy` 0, `empty` 1, `full` 0, `out_valid` 0 and `in_ready` 1.
- R2: A write is accepted when `in_valid` and `in_ready` are both high, and it raises `occupancy` by one. When `occupancy` reaches `2*PE_CNT`, `full` goes high and `in_ready` goes low. A key offered while full is not stored.
- R3: `out_valid` is high exactly when `occupancy` is nonzero. Each accepted read lowers `occupancy` by one, and `empty` is high exactly when `occupancy` is 0.
- R4: The keys read out after a burst of writes are in non-decreasing unsigned order. They are a permutation of the keys written, and each copy of a duplicate key appears exactly once.
- R5: After any accepted read, `in_ready` stays low until `occupancy` returns to 0.
- R6: When a read is accepted (`out_valid` and `out_ready` both high), `in_ready` is low in that same cycle. A write offered alongside it is therefore refused.
- R7: While `out_valid` is high, `out_ready` is low and `in_valid` is low, `out_key` holds its value.
- R8: With `out_ready` held high from the cycle after the last write, a burst of N keys leaves on N consecutive clock edges with no idle cycle. This gives 2N cycles for a write-then-read pass.
- R9: A key with every bit set is stored, sorted and returned like any other key, with no confusion with an empty slot.
- R10: Reading may begin at any fill level from 1 to `2*PE_CNT`, and the order of R4 still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input key offered |
| in_ready | output | 1 | Sorter accepts a key this cycle |
| in_key | input | KEY_W | Unsigned key to insert |
| out_valid | output | 1 | A sorted key is offered |
| out_ready | input | 1 | Consumer takes the offered key |
| out_key | output | KEY_W | Smallest key still held |
| full | output | 1 | All `2*PE_CNT` slots in use |
| empty | output | 1 | No key held |
| occupancy | output | $clog2(2*PE_CNT+1) | Number of keys held |

## Verification
The bench builds the sorter with 8-bit keys and four cells, for a capacity of eight keys. At that size the following cases are all reached in a few dozen cycles:
- a completely full chain and a refused ninth key;
- an all-ones key and an all-zero key in the same burst;
- runs of identical keys;
- bursts in both presorted and reversed order.

Single-key and partial bursts also exercise reading from a chain whose lower cells still hold keys in transit. Bursts of random length drawn from a small key range add further duplicates.

// File: rtl/sstack_pkg.sv
package sstack_pkg;
  typedef enum logic {
    PH_FILL  = 1'b0,
    PH_DRAIN = 1'b1
  } phase_e;
endpackage

// File: rtl/sstack_cell.sv
// One compare-exchange cell: two key slots, one comparator.
module sstack_cell #(
  parameter int KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_push,
  input  logic             step_pop,
  input  logic             above_vld,
  input  logic [KEY_W-1:0] above_key,
  input  logic             below_vld,
  input  logic [KEY_W-1:0] below_key,
  output logic             lo_vld,
  output logic [KEY_W-1:0] lo_key,
  output logic             hi_vld,
  output logic [KEY_W-1:0] hi_key
);
  logic             a_vld, b_vld, b_first;
  logic [KEY_W-1:0] a_key, b_key;

  // Push: resident small key against the key from above.
  // Pop:  resident large key against the key from below.
  always_comb begin
    if (step_push) begin
      a_vld = lo_vld;    a_key = lo_key;
      b_vld = above_vld; b_key = above_key;
    end else begin
      a_vld = hi_vld;    a_key = hi_key;
      b_vld = below_vld; b_key = below_key;
    end
    // An empty slot ranks above every real key.
    b_first = b_vld && (!a_vld || (b_key < a_key));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_vld <= 1'b0;
      hi_vld <= 1'b0;
      lo_key <= '0;
      hi_key <= '0;
    end else if (step_push || step_pop) begin
      // On push the old hi has just moved down; on pop the old lo has moved up.
      lo_vld <= b_first ? b_vld : a_vld;
      lo_key <= b_first ? b_key : a_key;
      hi_vld <= b_first ? a_vld : b_vld;
      hi_key <= b_first ? a_key : b_key;
    end
  end
endmodule

// File: rtl/sstack_ctrl.sv
// Occupancy, phase and handshake control.
module sstack_ctrl
  import sstack_pkg::*;
#(
  parameter int CAP   = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             push_step,
  output logic             pop_step,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] occupancy
);
  localparam logic [CNT_W-1:0] CAP_C = CNT_W'(CAP);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  phase_e phase_q;

  always_comb begin
    empty     = (occupancy == '0);
    full      = (occupancy == CAP_C);
    out_valid = !empty;
    pop_step  = out_valid && out_ready;
    in_ready  = (phase_q == PH_FILL) && !full && !pop_step;
    push_step = in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_FILL;
      occupancy <= '0;
    end else if (push_step) begin
      occupancy <= occupancy + ONE_C;
    end else if (pop_step) begin
      occupancy <= occupancy - ONE_C;
      phase_q   <= (occupancy == ONE_C) ? PH_FILL : PH_DRAIN;
    end
  end
endmodule

// File: rtl/sstack_sorter.sv
// Stack of compare-exchange cells, top cell at the ports.
module sstack_sorter #(
  parameter int KEY_W  = 8,
  parameter int PE_CNT = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [KEY_W-1:0]                    in_key,
  output logic                                out_valid,
  input  logic                                out_ready,
  output logic [KEY_W-1:0]                    out_key,
  output logic                                full,
  output logic                                empty,
  output logic [$clog2(2*PE_CNT+1)-1:0]       occupancy
);
  localparam int CAP   = 2 * PE_CNT;
  localparam int CNT_W = $clog2(CAP + 1);

  logic             push_step, pop_step;
  logic             lo_v [PE_CNT];
  logic             hi_v [PE_CNT];
  logic [KEY_W-1:0] lo_k [PE_CNT];
  logic [KEY_W-1:0] hi_k [PE_CNT];

  sstack_ctrl #(.CAP(CAP), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .push_step (push_step),
    .pop_step  (pop_step),
    .full      (full),
    .empty     (empty),
    .occupancy (occupancy)
  );

  for (genvar i = 0; i < PE_CNT; i++) begin : g_cell
    logic             up_v, dn_v;
    logic [KEY_W-1:0] up_k, dn_k;

    if (i == 0) begin : g_top
      assign up_v = 1'b1;
      assign up_k = in_key;
    end else begin : g_mid_up
      assign up_v = hi_v[i-1];
      assign up_k = hi_k[i-1];
    end

    if (i == PE_CNT - 1) begin : g_bottom
      assign dn_v = 1'b0;
      assign dn_k = '0;
    end else begin : g_mid_dn
      assign dn_v = lo_v[i+1];
      assign dn_k = lo_k[i+1];
    end

    sstack_cell #(.KEY_W(KEY_W)) u_cell (
      .clk       (clk),
      .rst       (rst),
      .step_push (push_step),
      .step_pop  (pop_step),
      .above_vld (up_v),
      .above_key (up_k),
      .below_vld (dn_v),
      .below_key (dn_k),
      .lo_vld    (lo_v[i]),
      .lo_key    (lo_k[i]),
      .hi_vld    (hi_v[i]),
      .hi_key    (hi_k[i])
    );
  end

  assign out_key = lo_k[0];
endmodule

// File: rtl/sstack_sorter_chk.sv
module sstack_sorter_chk #(
  parameter int KEY_W = 8,
  parameter int CAP   = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [KEY_W-1:0] out_key,
  input logic             full,
  input logic [CNT_W-1:0] occupancy,
  input logic             top_vld
);
  a_r2_full_blocks: assert property (@(posedge clk) disable iff (rst)
    full |-> !in_ready);

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    occupancy <= CNT_W'(CAP));

  a_r2_count_up: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> occupancy == CNT_W'($past(occupancy) + 1'b1));

  a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> occupancy == CNT_W'($past(occupancy) - 1'b1));

  a_r3_top_holds_key: assert property (@(posedge clk) disable iff (rst)
    out_valid == top_vld);

  a_r4_ascending: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (!out_valid || out_key >= $past(out_key)));

  a_r5_input_closed: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (in_ready == (occupancy == '0)));

  a_r6_pop_wins: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |-> !in_ready);

  a_r7_key_held: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !in_valid) |=> $stable(out_key));
endmodule

bind sstack_sorter sstack_sorter_chk #(
  .KEY_W (KEY_W),
  .CAP   (CAP),
  .CNT_W (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_key   (out_key),
  .full      (full),
  .occupancy (occupancy),
  .top_vld   (lo_v[0])
);

// File: tb/tb_sstack_sorter.sv
`timescale 1ns/1ps
module tb_sstack_sorter;
  localparam int KEY_W  = 8;
  localparam int PE_CNT = 4;
  localparam int CAP    = 2 * PE_CNT;
  localparam int CNT_W  = $clog2(CAP + 1);
  localparam int NB     = 7;

  // Burst table: length, keys packed with key j at bits [8j +: 8].
  localparam int B_LEN [NB] = '{8, 1, 5, 8, 8, 3, 2};
  localparam logic [63:0] B_KEYS [NB] = '{
    64'h00_7E_03_80_11_FF_03_5A,  // mixed, duplicates, all-ones, zero
    64'h00_00_00_00_00_00_00_42,  // single key
    64'h00_00_00_09_09_09_09_09,  // all equal
    64'h08_07_06_05_04_03_02_01,  // presorted
    64'h80_90_A0_B0_C0_D0_E0_F0,  // reversed
    64'h00_00_00_00_00_00_FF_FF,  // all-ones pair then zero
    64'h00_00_00_00_00_00_10_77   // pair
  };

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid, in_ready, out_valid, out_ready, full, empty;
  logic [KEY_W-1:0] in_key, out_key;
  logic [CNT_W-1:0] occupancy;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  logic [KEY_W-1:0] kbuf [CAP];
  logic [KEY_W-1:0] ebuf [CAP];

  always #2.5 clk = ~clk;

  sstack_sorter #(.KEY_W(KEY_W), .PE_CNT(PE_CNT)) dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_key    (in_key),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_key   (out_key),
    .full      (full),
    .empty     (empty),
    .occupancy (occupancy)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_key = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1", "occupancy", occupancy, 0);
    chk("R1", "empty", empty, 1);
    chk("R1", "full", full, 0);
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "in_ready", in_ready, 1);
  endtask

  // Push n keys from kbuf back to back, then drain with out_ready high.
  task automatic run_burst(input int n, input string tag);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      in_valid = 1'b1; in_key = kbuf[j];
      #1 chk("R2", {tag, " in_ready while filling"}, in_ready, 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk("R2", {tag, " occupancy after fill"}, occupancy, n);
    chk("R2", {tag, " full flag"}, full, (n == CAP));
    // Reference order: plain exchange sort in the bench.
    for (int j = 0; j < n; j++) ebuf[j] = kbuf[j];
    for (int a = 0; a < n; a++)
      for (int b = 0; b < n - 1 - a; b++)
        if (ebuf[b] > ebuf[b+1]) begin
          logic [KEY_W-1:0] t;
          t = ebuf[b]; ebuf[b] = ebuf[b+1]; ebuf[b+1] = t;
        end
    out_ready = 1'b1;
    for (int j = 0; j < n; j++) begin
      #1;
      chk("R8", {tag, " out_valid each drain cycle"}, out_valid, 1);
      chk("R4", {tag, " sorted key"}, out_key, ebuf[j]);
      @(negedge clk);
    end
    out_ready = 1'b0;
    #1;
    chk("R3", {tag, " empty after drain"}, empty, 1);
    chk("R3", {tag, " out_valid after drain"}, out_valid, 0);
    chk("R5", {tag, " input reopens when empty"}, in_ready, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_key = '0;
    do_reset();

    // Table walk: R4, R8, R9 (0xFF keys), R10 (partial fills).
    for (int b = 0; b < NB; b++) begin
      for (int j = 0; j < CAP; j++) kbuf[j] = B_KEYS[b][8*j +: 8];
      run_burst(B_LEN[b], $sformatf("R9/R10 table burst %0d", b));
    end

    // Random bursts from a small key range for duplicates.
    for (int r = 0; r < 6; r++) begin
      int n;
      n = 1 + int'($urandom_range(CAP - 1));
      for (int j = 0; j < CAP; j++) kbuf[j] = KEY_W'($urandom_range(15));
      run_burst(n, $sformatf("R10 random burst %0d", r));
    end

    // R2: overfill refused, offered key not stored.
    for (int j = 0; j < CAP; j++) begin
      @(negedge clk); in_valid = 1'b1; in_key = KEY_W'(CAP - j);
    end
    @(negedge clk);
    in_key = 8'h00;
    #1;
    chk("R2", "in_ready when full", in_ready, 0);
    chk("R2", "full flag", full, 1);
    @(negedge clk);
    in_valid = 1'b0;
    #1 chk("R2", "occupancy after refused key", occupancy, CAP);
    // R7: key held while consumer stalls.
    repeat (3) @(negedge clk);
    #1 chk("R7", "out_key held under stall", out_key, 1);
    out_ready = 1'b1;
    for (int j = 0; j < CAP; j++) begin
      #1 chk("R2", "drain after overfill (refused 0 absent)", out_key, j + 1);
      @(negedge clk);
    end
    out_ready = 1'b0;

    // R6 and R5: concurrent offer, then input closed during drain.
    kbuf[0] = 8'd30; kbuf[1] = 8'd10; kbuf[2] = 8'd20;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk); in_valid = 1'b1; in_key = kbuf[j];
    end
    @(negedge clk);
    in_key = 8'd5; out_ready = 1'b1;
    #1;
    chk("R6", "in_ready during accepted pop", in_ready, 0);
    chk("R6", "popped key", out_key, 10);
    @(negedge clk);
    out_ready = 1'b0;
    #1;
    chk("R5", "in_ready after pop", in_ready, 0);
    chk("R6", "occupancy (push refused)", occupancy, 2);
    @(negedge clk);
    #1 chk("R5", "occupancy while input closed", occupancy, 2);
    in_valid = 1'b0; out_ready = 1'b1;
    #1 chk("R6", "next key (5 not stored)", out_key, 20);
    @(negedge clk);
    #1 chk("R4", "last key", out_key, 30);
    @(negedge clk);
    out_ready = 1'b0;
    #1 chk("R5", "in_ready when empty again", in_ready, 1);

    // R1: reset in the middle of a fill.
    for (int j = 0; j < 2; j++) begin
      @(negedge clk); in_valid = 1'b1; in_key = 8'h33;
    end
    do_reset();

    finish_run();
  end
endmodule